// File: doc/BRIEF.md
# Reference Clock Output Generator

This block produces a reference clock for an output pin. The clock is divided from one of two sources: the primary oscillator clock or the current system clock. A 16-bit control word sets the enable, the source, whether the output may run during sleep, and a 4-bit divider code. The code passes the source through unchanged (code 0) or divides it by a power of two with an even duty cycle.

Both source clocks are treated as asynchronous levels. A fast block clock oversamples them through synchronizers, and a small state machine owns the divided output. The machine has four states:
- `ST_IDLE`: the output is held low. The requested configuration is copied into the active configuration.
- `ST_SYNC`: the counter is cleared, and the machine waits for the new source to be low.
- `ST_RUN`: the output follows the divider tap.
- `ST_DRAIN`: a disable, gating or configuration change is pending, and the machine waits for the tap to go low.

The transitions are:
- IDLE→SYNC when the output is allowed to run.
- SYNC→RUN when the synchronized source is low.
- SYNC→IDLE when the output is no longer allowed or the request changed.
- RUN→DRAIN when the output is no longer allowed or the request differs from the active configuration.
- DRAIN→IDLE when the tap is low.

The block also drives a request that keeps the primary oscillator powered during sleep. The request is raised while the primary oscillator is the active source of a non-idle output, so that a drain in progress can finish.

Top module: `refclk_out`

## Requirements
- R1: During and right after reset, `refo_o` and `posc_req_o` are 0.
- R2: While the enable bit (ctrl bit 15) is 0, `refo_o` stays 0 once any pulse in progress has ended, and the machine leaves `ST_RUN`.
- R3: With divider code c = ctrl bits 11:8 and a source of half period H block-clock cycles, code 0 gives high and low phases of H cycles each. Code n from 1 to MAX_CODE gives high and low phases of H·2^n cycles each.
- R4: Source select (ctrl bit 12) = 1 uses `posc_clk_i`, and 0 uses `sys_clk_i`.
- R5: A divider code above MAX_CODE behaves as MAX_CODE.
- R6: While `sleep_i` is 1, the output keeps running only if ctrl bit 13 (sleep run) and bit 12 are both 1 and `posc_primary_i` is 1.
- R7: During sleep without those three conditions, the output stops and stays low.
- R8: `posc_req_o`, registered, is 1 when any of the following holds: `posc_keep_i` is 1; bits 15, 13 and 12 and `posc_primary_i` are all 1; the machine is not idle with the primary source active. Otherwise it is 0.
- R9: With bit 12 = 0, the output period follows a change of the system clock period.
- R10: The active divider code and source change only in `ST_IDLE`. A change requested while running waits for the tap to be low, so no high phase is cut short.
- R11: In `ST_IDLE` the output is low. A restart enters `ST_RUN` only after the new source has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast block clock that oversamples the sources |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 16 | Control word: bit15 enable, bit13 sleep run, bit12 source, bits11:8 code |
| posc_clk_i | input | 1 | Primary oscillator clock (asynchronous) |
| sys_clk_i | input | 1 | Current system clock (asynchronous) |
| sleep_i | input | 1 | Device is in sleep |
| posc_keep_i | input | 1 | Primary oscillator is configured to stay on in sleep |
| posc_primary_i | input | 1 | Device clock is configured in a primary oscillator mode |
| refo_o | output | 1 | Divided reference clock |
| posc_req_o | output | 1 | Request to keep the primary oscillator powered |

## Verification
The bench builds the block with MAX_CODE = 6 and two synchronizer stages. This keeps the longest divided period at a few hundred cycles, so every legal code can be measured on both sources, and a code above the limit exercises the clamp. The source half periods are 3 and 5 cycles, and the system half period later changes to 7, so each measured phase width identifies both the source and the code. A pulse monitor looks for any shortened high phase while codes, sources and sleep conditions change mid-run.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_RUN,
        ST_DRAIN
    } refclk_state_e;

    localparam int CTRL_W   = 16;
    localparam int EN_BIT   = 15;
    localparam int SLP_BIT  = 13;
    localparam int SEL_BIT  = 12;
    localparam int CODE_LSB = 8;
    localparam int CODE_W   = 4;

endpackage

// File: rtl/refclk_sync.sv
module refclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_i};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign level_o = sh_q[STAGES-1];
    assign rise_o  = sh_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/refclk_divcnt.sv
module refclk_divcnt
    import refclk_pkg::*;
#(
    parameter int MAX_CODE = 15
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    input  logic              step_i,
    input  logic              lvl_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              tap_o
);
    localparam int CNT_W = (MAX_CODE < 1) ? 1 : MAX_CODE;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Code 0 passes the source level; code n taps counter bit n-1.
    always_comb begin
        tap_o = lvl_i;
        for (int k = 1; k <= MAX_CODE; k++) begin
            if (code_i == CODE_W'(k)) begin
                tap_o = cnt_q[k-1];
            end
        end
    end
endmodule

// File: rtl/refclk_out.sv
module refclk_out
    import refclk_pkg::*;
#(
    parameter int MAX_CODE    = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic              posc_clk_i,
    input  logic              sys_clk_i,
    input  logic              sleep_i,
    input  logic              posc_keep_i,
    input  logic              posc_primary_i,
    output logic              refo_o,
    output logic              posc_req_o
);
    localparam int NSRC = 2;  // index 1: primary, index 0: system

    logic [NSRC-1:0] src_raw, src_lvl, src_rise;
    assign src_raw = {posc_clk_i, sys_clk_i};

    for (genvar g = 0; g < NSRC; g++) begin : g_sync
        refclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .async_i (src_raw[g]),
            .level_o (src_lvl[g]),
            .rise_o  (src_rise[g])
        );
    end

    refclk_state_e     state_q, state_d;
    logic              act_sel_q;
    logic [CODE_W-1:0] act_code_q;
    logic              refo_q, req_q;

    // Requested configuration, code clamped to the supported range.
    logic [CODE_W-1:0] raw_code, want_code;
    logic              want_sel, sleep_ok, run_ok, cfg_match;

    assign raw_code  = ctrl_i[CODE_LSB +: CODE_W];
    assign want_code = (int'(raw_code) > MAX_CODE) ? CODE_W'(MAX_CODE) : raw_code;
    assign want_sel  = ctrl_i[SEL_BIT];
    assign sleep_ok  = ctrl_i[SLP_BIT] & ctrl_i[SEL_BIT] & posc_primary_i;
    assign run_ok    = ctrl_i[EN_BIT] & (~sleep_i | sleep_ok);
    assign cfg_match = (act_sel_q == want_sel) && (act_code_q == want_code);

    logic sel_lvl, sel_rise, tap, cnt_clr, cnt_step, running;
    assign sel_lvl  = src_lvl[act_sel_q];
    assign sel_rise = src_rise[act_sel_q];
    assign running  = (state_q == ST_RUN) || (state_q == ST_DRAIN);
    assign cnt_clr  = ~running;
    assign cnt_step = running & sel_rise;

    refclk_divcnt #(.MAX_CODE(MAX_CODE)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr),
        .step_i (cnt_step),
        .lvl_i  (sel_lvl),
        .code_i (act_code_q),
        .tap_o  (tap)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_ok) state_d = ST_SYNC;
            ST_SYNC: begin
                if (!run_ok || !cfg_match) state_d = ST_IDLE;
                else if (!sel_lvl)         state_d = ST_RUN;
            end
            ST_RUN:   if (!run_ok || !cfg_match) state_d = ST_DRAIN;
            ST_DRAIN: if (!tap) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and active configuration.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q    <= ST_IDLE;
            act_sel_q  <= 1'b0;
            act_code_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                act_sel_q  <= want_sel;
                act_code_q <= want_code;
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            refo_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            refo_q <= running & tap;
            req_q  <= posc_keep_i
                    | (ctrl_i[EN_BIT] & sleep_ok)
                    | ((state_q != ST_IDLE) & act_sel_q);
        end
    end

    assign refo_o     = refo_q;
    assign posc_req_o = req_q;
endmodule

// File: rtl/refclk_out_chk.sv
module refclk_out_chk
    import refclk_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CTRL_W-1:0] ctrl_i,
    input logic              sleep_i,
    input logic              posc_keep_i,
    input logic              posc_primary_i,
    input logic              refo_o,
    input logic              posc_req_o,
    input refclk_state_e     state_i,
    input logic [CODE_W-1:0] act_code_i
);
    // R11
    idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_IDLE) |-> !refo_o);

    // R8
    keep_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        posc_keep_i |=> posc_req_o);

    // R6
    sleep_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_i[EN_BIT] && ctrl_i[SLP_BIT] && ctrl_i[SEL_BIT] && posc_primary_i) |=> posc_req_o);

    // R10
    code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_RUN && $past(state_i) == ST_RUN) |-> $stable(act_code_i));

    // R7
    sleep_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_RUN && sleep_i && !(ctrl_i[SLP_BIT] && ctrl_i[SEL_BIT] && posc_primary_i))
        |=> (state_i != ST_RUN));

    // R2
    disable_leave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_i == ST_RUN && !ctrl_i[EN_BIT]) |=> (state_i != ST_RUN));
endmodule

bind refclk_out refclk_out_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_i         (ctrl_i),
    .sleep_i        (sleep_i),
    .posc_keep_i    (posc_keep_i),
    .posc_primary_i (posc_primary_i),
    .refo_o         (refo_o),
    .posc_req_o     (posc_req_o),
    .state_i        (state_q),
    .act_code_i     (act_code_q)
);

// File: tb/refclk_out_tb.sv
module refclk_out_tb_top;
    localparam int MAXC = 6;
    localparam int PH   = 3;  // primary half period

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctrl = '0;
    logic        posc = 1'b0, sysc = 1'b0;
    logic        sleep = 1'b0, keep = 1'b0, prim = 1'b0;
    logic        refo, req;

    int checks = 0, fails = 0, runts = 0, hi_run = 0, cyc = 0;
    int pc = 0, sc = 0, sys_h = 5;

    always #10 clk = ~clk;  // 50 MHz

    refclk_out #(.MAX_CODE(MAXC), .SYNC_STAGES(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl),
        .posc_clk_i(posc), .sys_clk_i(sysc), .sleep_i(sleep),
        .posc_keep_i(keep), .posc_primary_i(prim),
        .refo_o(refo), .posc_req_o(req)
    );

    // Source generators.
    always @(negedge clk) begin
        if (pc >= PH - 1) begin pc <= 0; posc <= ~posc; end else pc <= pc + 1;
        if (sc >= sys_h - 1) begin sc <= 0; sysc <= ~sysc; end else sc <= sc + 1;
    end

    // R10 pulse monitor: every high phase must last at least the shortest half period.
    always @(negedge clk) begin
        if (rst_n && refo === 1'b1) hi_run <= hi_run + 1;
        else begin
            if (hi_run > 0 && hi_run < PH) runts <= runts + 1;
            hi_run <= 0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycle %0d expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] mk(bit en, bit slp, bit sel, int code);
        logic [15:0] w = '0;
        w[15] = en; w[13] = slp; w[12] = sel; w[11:8] = 4'(code);
        return w;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic seek_rise();
        while (refo !== 1'b0) @(negedge clk);
        while (refo !== 1'b1) @(negedge clk);
    endtask

    task automatic measure(string req, int exp_half);
        int hi = 0, lo = 0;
        seek_rise(); seek_rise();
        while (refo === 1'b1) begin hi++; @(negedge clk); end
        while (refo === 1'b0) begin lo++; @(negedge clk); end
        chk({req, " high"}, hi, exp_half);
        chk({req, " low"}, lo, exp_half);
    endtask

    task automatic quiet(string req, int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (refo !== 1'b0) seen++;
        end
        chk(req, seen, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 refo in reset", int'(refo), 0);
        chk("R1 req in reset", int'(req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 refo after reset", int'(refo), 0);
        chk("R1 req after reset", int'(req), 0);

        // R2 / R11: disabled with a nonzero code stays low.
        ctrl = mk(0, 0, 1, 2);
        quiet("R2 disabled output", 300);

        // R3 / R4: primary source, all codes.
        for (int n = 0; n <= MAXC; n++) begin
            ctrl = mk(1, 0, 1, n);
            measure($sformatf("R3 R4 primary code %0d", n), PH << n);
        end
        // R3 / R4 / R10: system source, all codes, switching live.
        for (int n = 0; n <= MAXC; n++) begin
            ctrl = mk(1, 0, 0, n);
            measure($sformatf("R3 R4 system code %0d", n), 5 << n);
        end
        // R5: codes above the limit clamp.
        ctrl = mk(1, 0, 1, 15);
        measure("R5 clamp code 15", PH << MAXC);
        ctrl = mk(1, 0, 1, 9);
        measure("R5 clamp code 9", PH << MAXC);

        // R9: system clock period change is followed.
        ctrl = mk(1, 0, 0, 2);
        measure("R9 before switch", 5 << 2);
        sys_h = 7;
        measure("R9 after switch", 7 << 2);

        // R2: disabling while running stops the output.
        ctrl = mk(0, 0, 0, 2);
        repeat (200) @(negedge clk);
        quiet("R2 disabled after run", 200);

        // R8: keep-on and sleep-run request.
        keep = 1'b1; repeat (3) @(negedge clk);
        chk("R8 keep request", int'(req), 1);
        keep = 1'b0; repeat (3) @(negedge clk);
        chk("R8 request released", int'(req), 0);
        prim = 1'b1;
        ctrl = mk(1, 1, 1, 1);
        repeat (3) @(negedge clk);
        chk("R8 sleep-run request", int'(req), 1);

        // R6: runs during sleep when all conditions hold.
        sleep = 1'b1;
        measure("R6 sleep running", PH << 1);

        // R7: sleep without sleep-run bit.
        ctrl = mk(1, 0, 1, 1);
        repeat (100) @(negedge clk);
        quiet("R7 sleep no run bit", 200);
        chk("R8 request dropped in sleep", int'(req), 0);
        // R7: sleep with system source.
        ctrl = mk(1, 1, 0, 1);
        repeat (100) @(negedge clk);
        quiet("R7 sleep system source", 200);
        // R7: sleep without primary mode.
        prim = 1'b0;
        ctrl = mk(1, 1, 1, 1);
        repeat (100) @(negedge clk);
        quiet("R7 sleep not primary", 200);

        // Wake: output resumes (R11 restart).
        sleep = 1'b0;
        measure("R11 resume after wake", PH << 1);

        // R10: no runt pulse across all changes.
        chk("R10 runt pulses", runts, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule